// File: doc/BRIEF.md
# Control Register Write Side-Effect Unit

This block holds the processor control registers CR0, CR2, CR3, CR4 and CR8, the extended feature register (EFER), the code and stack segment attribute words and the six data segment base registers. A single write port updates one register per cycle, and the write carries its side effects: when paging is switched on or off with long mode enabled, the long-mode-active flag follows. Paging and paging-feature changes raise translation-buffer flush pulses. A CR3 load flushes non-global entries. The effective segment bases follow the stored bases, or are forced to zero, depending on whether the core runs in 64-bit mode.

A combinational read port returns the register selected by an index. Indices that name no register raise a one-cycle error and change nothing. The effective bases leave the block on a flat output bus for the address generation logic. The flush pulses go to the instruction and data translation buffers, which are not part of this block.

Top module: `ctlreg_unit`

## Requirements
- R1: After reset CR0 reads 0x00000010 (bit 4 set), every other register, every effective base, every flush output and the error output are 0.
- R2: CR0 bit 4 is always stored as 1, whatever value is written.
- R3: A CR0 write that changes bit 31 (paging) while EFER bit 8 (long mode enable) is 1 sets EFER bit 10 (long mode active) to the new bit 31. If EFER bit 8 is 0, bit 10 is left unchanged.
- R4: A CR0 write that changes bit 31 sets both flush-all outputs (bit 0 instruction, bit 1 data) in the cycle after the write. A CR0 write that keeps bit 31 raises no flush.
- R5: Every CR3 write sets both flush-non-global outputs in the cycle after the write.
- R6: A CR4 write that changes bit 4, bit 5 or bit 7 sets both flush-all outputs in the next cycle. A CR4 write that changes only other bits raises no flush.
- R7: Flush outputs are high for exactly one cycle per causing write and are low in any cycle not preceded by such a write.
- R8: A code segment attribute write that changes bit 9 (long) from 0 to 1 clears the effective bases of ES, CS, SS and DS. A change from 1 to 0 loads each of them with its stored base.
- R9: A write to the ES, CS, SS or DS base always updates the stored base. It updates the effective base only when EFER bit 10 and code segment attribute bit 9 are not both 1. FS and GS base writes always update their effective base.
- R10: A write or a read enable with an illegal index (1, 5 to 7, 9 to 15, 25 to 31) raises the error output for one cycle, starting in the next cycle, and leaves all state unchanged. An illegal read index returns 0.
- R11: An EFER write never changes bit 10; all other EFER bits take the written value.
- R12: The read data is the current value at the read index: 0 CR0, 2 CR2, 3 CR3, 4 CR4, 8 CR8, 16 EFER, 17 code attributes, 18 stack attributes, 19 to 24 the stored bases of ES, CS, SS, DS, FS, GS. Effective base of segment i is on bits 32*i+31 to 32*i of the base bus, in that same segment order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Register index of the write |
| wr_data | input | 32 | Write value |
| rd_en | input | 1 | Read strobe, used only for error reporting |
| rd_idx | input | 5 | Register index of the read |
| rd_data | output | 32 | Value of the register at rd_idx |
| err | output | 1 | One-cycle pulse after an illegal access |
| tlb_flush_all | output | 2 | Flush-all pulses, bit 0 instruction, bit 1 data |
| tlb_flush_ng | output | 2 | Flush-non-global pulses, bit 0 instruction, bit 1 data |
| eff_base | output | 192 | Effective bases of ES, CS, SS, DS, FS, GS |

## Verification
The assertions take it that at most one register is written per cycle and that wr_idx and wr_data are known whenever wr_en is high. They also rely on the previous-cycle value of a register being the old value that a toggle is measured against. The stimulus changes inputs only between clock edges, holds wr_en for a single cycle per access and returns it low before the next one. Illegal indices and mode changes are sent through that same port, so no state is ever forced from outside.

// File: rtl/ctlreg_pkg.sv
// Shared constants and types for the control register unit.
// Assumes 32-bit registers and a 5-bit index space.
package ctlreg_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 5;
    localparam int NSEG   = 6;   // ES, CS, SS, DS, FS, GS
    localparam int NSHAD  = 4;   // segments whose base is ignored in 64-bit mode
    localparam int NTLB   = 2;   // instruction, data

    localparam int IDX_CR0   = 0;
    localparam int IDX_CR2   = 2;
    localparam int IDX_CR3   = 3;
    localparam int IDX_CR4   = 4;
    localparam int IDX_CR8   = 8;
    localparam int IDX_EFER  = 16;
    localparam int IDX_CSA   = 17;
    localparam int IDX_SSA   = 18;
    localparam int IDX_BASE0 = 19;

    localparam int CR0_ET   = 4;
    localparam int CR0_PG   = 31;
    localparam int CR4_PSE  = 4;
    localparam int CR4_PAE  = 5;
    localparam int CR4_PGE  = 7;
    localparam int EFER_LME = 8;
    localparam int EFER_LMA = 10;
    localparam int ATTR_LNG = 9;

    localparam logic [DATA_W-1:0] CR0_RST  = DATA_W'(1) << CR0_ET;
    localparam logic [DATA_W-1:0] CR4_MASK = (DATA_W'(1) << CR4_PSE) |
                                             (DATA_W'(1) << CR4_PAE) |
                                             (DATA_W'(1) << CR4_PGE);

    typedef struct packed {
        logic            legal;
        logic            cr0;
        logic            cr2;
        logic            cr3;
        logic            cr4;
        logic            cr8;
        logic            efer;
        logic            csa;
        logic            ssa;
        logic [NSEG-1:0] seg;
    } sel_t;
endpackage

// File: rtl/ctlreg_decode.sv
// Index decoder: turns a register index into one-hot selects and a
// legality flag. Purely combinational; unmapped indices select nothing.
module ctlreg_decode
    import ctlreg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output sel_t             sel
);
    // Decode the index into one select bit.
    always_comb begin
        sel      = '0;
        sel.cr0  = (idx == IDX_W'(IDX_CR0));
        sel.cr2  = (idx == IDX_W'(IDX_CR2));
        sel.cr3  = (idx == IDX_W'(IDX_CR3));
        sel.cr4  = (idx == IDX_W'(IDX_CR4));
        sel.cr8  = (idx == IDX_W'(IDX_CR8));
        sel.efer = (idx == IDX_W'(IDX_EFER));
        sel.csa  = (idx == IDX_W'(IDX_CSA));
        sel.ssa  = (idx == IDX_W'(IDX_SSA));
        for (int s = 0; s < NSEG; s++) begin
            sel.seg[s] = (idx == IDX_W'(IDX_BASE0 + s));
        end
        sel.legal = sel.cr0 | sel.cr2 | sel.cr3 | sel.cr4 | sel.cr8 |
                    sel.efer | sel.csa | sel.ssa | (|sel.seg);
    end
endmodule

// File: rtl/ctlreg_flush.sv
// Flush pulse generator: registers one-cycle flush-all and
// flush-non-global pulses for each translation buffer.
// Assumes the old register values are presented in the write cycle.
module ctlreg_flush
    import ctlreg_pkg::*;
#(
    parameter int N_TLB = NTLB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cr0,
    input  logic              wr_cr3,
    input  logic              wr_cr4,
    input  logic [DATA_W-1:0] cr0_old,
    input  logic [DATA_W-1:0] cr4_old,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_TLB-1:0]  flush_all,
    output logic [N_TLB-1:0]  flush_ng
);
    logic need_all;

    // A paging toggle or a paging-feature toggle calls for a full flush.
    always_comb begin
        need_all = (wr_cr0 & (cr0_old[CR0_PG] ^ wr_data[CR0_PG])) |
                   (wr_cr4 & (|((cr4_old ^ wr_data) & CR4_MASK)));
    end

    for (genvar t = 0; t < N_TLB; t++) begin : g_tlb
        // Register the pulses for buffer t.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flush_all[t] <= 1'b0;
                flush_ng[t]  <= 1'b0;
            end else begin
                flush_all[t] <= need_all;
                flush_ng[t]  <= wr_cr3;
            end
        end
    end
endmodule

// File: rtl/ctlreg_segbase.sv
// Segment base store: keeps the stored and effective base of each
// segment. The first N_SHAD segments are shadowed by 64-bit mode.
// Assumes at most one of wr_seg, enter_long, leave_long per cycle.
module ctlreg_segbase
    import ctlreg_pkg::*;
#(
    parameter int N_SEG  = NSEG,
    parameter int N_SHAD = NSHAD
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SEG-1:0]        wr_seg,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    in_64bit,
    input  logic                    enter_long,
    input  logic                    leave_long,
    output logic [N_SEG*DATA_W-1:0] base_flat,
    output logic [N_SEG*DATA_W-1:0] eff_flat
);
    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        logic [DATA_W-1:0] base_q;
        logic [DATA_W-1:0] eff_q;

        // Stored base follows every write to this segment.
        always_ff @(posedge clk) begin
            if (!rst_n)         base_q <= '0;
            else if (wr_seg[s]) base_q <= wr_data;
        end

        if (s < N_SHAD) begin : g_shad
            // Effective base: cleared on long entry, restored on exit.
            always_ff @(posedge clk) begin
                if (!rst_n)                       eff_q <= '0;
                else if (enter_long)              eff_q <= '0;
                else if (leave_long)              eff_q <= base_q;
                else if (wr_seg[s] && !in_64bit)  eff_q <= wr_data;
            end
        end else begin : g_plain
            // Effective base always tracks the written base.
            always_ff @(posedge clk) begin
                if (!rst_n)         eff_q <= '0;
                else if (wr_seg[s]) eff_q <= wr_data;
            end
        end

        assign base_flat[s*DATA_W +: DATA_W] = base_q;
        assign eff_flat[s*DATA_W +: DATA_W]  = eff_q;
    end
endmodule

// File: rtl/ctlreg_unit.sv
// Control register unit top: holds CR0/2/3/4/8, EFER and the segment
// attributes, applies write side effects and serves an indexed read.
// Assumes one write per cycle; illegal accesses change no state.
module ctlreg_unit
    import ctlreg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   rd_en,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   err,
    output logic [NTLB-1:0]        tlb_flush_all,
    output logic [NTLB-1:0]        tlb_flush_ng,
    output logic [NSEG*DATA_W-1:0] eff_base
);
    sel_t ws, rs;
    logic wr_ok, pg_tog, cs_tog, enter_long, leave_long, in_64bit;
    logic [DATA_W-1:0] cr0_q, cr2_q, cr3_q, cr4_q, cr8_q;
    logic [DATA_W-1:0] efer_q, csa_q, ssa_q;
    logic [DATA_W-1:0] cr0_new, efer_new;
    logic [NSEG*DATA_W-1:0] base_flat;

    ctlreg_decode u_wdec (.idx(wr_idx), .sel(ws));
    ctlreg_decode u_rdec (.idx(rd_idx), .sel(rs));

    // Derive the side-effect conditions of the current write.
    always_comb begin
        wr_ok      = wr_en & ws.legal;
        pg_tog     = wr_ok & ws.cr0 & (cr0_q[CR0_PG] ^ wr_data[CR0_PG]);
        cs_tog     = wr_ok & ws.csa & (csa_q[ATTR_LNG] ^ wr_data[ATTR_LNG]);
        enter_long = cs_tog & wr_data[ATTR_LNG];
        leave_long = cs_tog & ~wr_data[ATTR_LNG];
        in_64bit   = efer_q[EFER_LMA] & csa_q[ATTR_LNG];
        cr0_new    = wr_data | CR0_RST;
        efer_new   = wr_data;
        efer_new[EFER_LMA] = efer_q[EFER_LMA];
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr0_q <= CR0_RST;
            cr2_q <= '0;
            cr3_q <= '0;
            cr4_q <= '0;
            cr8_q <= '0;
            csa_q <= '0;
            ssa_q <= '0;
        end else if (wr_ok) begin
            if (ws.cr0) cr0_q <= cr0_new;
            if (ws.cr2) cr2_q <= wr_data;
            if (ws.cr3) cr3_q <= wr_data;
            if (ws.cr4) cr4_q <= wr_data;
            if (ws.cr8) cr8_q <= wr_data;
            if (ws.csa) csa_q <= wr_data;
            if (ws.ssa) ssa_q <= wr_data;
        end
    end

    // EFER storage with the long-mode-active flag driven by paging toggles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            efer_q <= '0;
        else if (wr_ok && ws.efer)
            efer_q <= efer_new;
        else if (pg_tog && efer_q[EFER_LME])
            efer_q[EFER_LMA] <= wr_data[CR0_PG];
    end

    // Error pulse for any illegal access.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= (wr_en & ~ws.legal) | (rd_en & ~rs.legal);
    end

    ctlreg_flush #(.N_TLB(NTLB)) u_flush (
        .clk(clk), .rst_n(rst_n),
        .wr_cr0(wr_ok & ws.cr0), .wr_cr3(wr_ok & ws.cr3),
        .wr_cr4(wr_ok & ws.cr4),
        .cr0_old(cr0_q), .cr4_old(cr4_q), .wr_data(wr_data),
        .flush_all(tlb_flush_all), .flush_ng(tlb_flush_ng)
    );

    ctlreg_segbase #(.N_SEG(NSEG), .N_SHAD(NSHAD)) u_seg (
        .clk(clk), .rst_n(rst_n),
        .wr_seg(ws.seg & {NSEG{wr_ok}}), .wr_data(wr_data),
        .in_64bit(in_64bit), .enter_long(enter_long), .leave_long(leave_long),
        .base_flat(base_flat), .eff_flat(eff_base)
    );

    // Read mux over all stored registers.
    always_comb begin
        rd_data = '0;
        if (rs.cr0)  rd_data = cr0_q;
        if (rs.cr2)  rd_data = cr2_q;
        if (rs.cr3)  rd_data = cr3_q;
        if (rs.cr4)  rd_data = cr4_q;
        if (rs.cr8)  rd_data = cr8_q;
        if (rs.efer) rd_data = efer_q;
        if (rs.csa)  rd_data = csa_q;
        if (rs.ssa)  rd_data = ssa_q;
        for (int s = 0; s < NSEG; s++) begin
            if (rs.seg[s]) rd_data = base_flat[s*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/ctlreg_chk.sv
// Property checker for ctlreg_unit, attached by bind below.
// Assumes one write per cycle and known inputs while wr_en is high.
module ctlreg_chk
    import ctlreg_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [IDX_W-1:0]       wr_idx,
    input logic [DATA_W-1:0]      wr_data,
    input logic [DATA_W-1:0]      cr0_q,
    input logic [DATA_W-1:0]      efer_q,
    input logic [DATA_W-1:0]      csa_q,
    input logic                   err,
    input logic [NTLB-1:0]        tlb_flush_all,
    input logic [NTLB-1:0]        tlb_flush_ng,
    input logic [NSEG*DATA_W-1:0] eff_base
);
    function automatic logic bad_idx(input logic [IDX_W-1:0] i);
        return !(i == 0 || (i >= 2 && i <= 4) || i == 8 ||
                 (i >= 16 && i <= 24));
    endfunction

    logic wcr0, wcr3;
    assign wcr0 = wr_en && (wr_idx == IDX_W'(IDX_CR0));
    assign wcr3 = wr_en && (wr_idx == IDX_W'(IDX_CR3));

    a_r2_et_forced: assert property (@(posedge clk) disable iff (!rst_n)
        wcr0 |=> cr0_q[CR0_ET]);

    a_r3_lma_follows_pg: assert property (@(posedge clk) disable iff (!rst_n)
        (wcr0 && (cr0_q[CR0_PG] != wr_data[CR0_PG]) && efer_q[EFER_LME])
        |=> efer_q[EFER_LMA] == $past(wr_data[CR0_PG]));

    a_r4_pg_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (wcr0 && (cr0_q[CR0_PG] != wr_data[CR0_PG]))
        |=> tlb_flush_all == {NTLB{1'b1}});

    a_r5_cr3_flush_ng: assert property (@(posedge clk) disable iff (!rst_n)
        wcr3 |=> tlb_flush_ng == {NTLB{1'b1}});

    a_r7_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (tlb_flush_all == '0) && (tlb_flush_ng == '0));

    a_r9_base_shadowed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IDX_W'(IDX_BASE0 + 3)) &&
         efer_q[EFER_LMA] && csa_q[ATTR_LNG])
        |=> $stable(eff_base[3*DATA_W +: DATA_W]));

    a_r10_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bad_idx(wr_idx))
        |=> err && $stable(cr0_q) && $stable(efer_q) && $stable(csa_q) &&
            $stable(eff_base));

    a_r11_lma_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IDX_W'(IDX_EFER)))
        |=> efer_q[EFER_LMA] == $past(efer_q[EFER_LMA]));
endmodule

bind ctlreg_unit ctlreg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .cr0_q(cr0_q), .efer_q(efer_q), .csa_q(csa_q),
    .err(err), .tlb_flush_all(tlb_flush_all), .tlb_flush_ng(tlb_flush_ng),
    .eff_base(eff_base)
);

// File: tb/sim_ctlreg_unit.sv
module sim_ctlreg_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_idx = '0;
    logic [31:0]  wr_data = '0;
    logic         rd_en = 1'b0;
    logic [4:0]   rd_idx = '0;
    logic [31:0]  rd_data;
    logic         err;
    logic [1:0]   tlb_flush_all, tlb_flush_ng;
    logic [191:0] eff_base;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    ctlreg_unit u0 (.*);

    typedef struct packed {
        logic        we;
        logic [4:0]  wi;
        logic [31:0] wd;
        logic [4:0]  ri;
        logic [31:0] erd;
        logic [1:0]  efa;
        logic [1:0]  eng;
        logic        eerr;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 5'd0,  32'h0000_0001, 5'd0,  32'h0000_0011, 2'b00, 2'b00, 1'b0}, // R2
        '{1'b1, 5'd16, 32'h0000_0100, 5'd16, 32'h0000_0100, 2'b00, 2'b00, 1'b0}, // R12
        '{1'b1, 5'd16, 32'h0000_0500, 5'd16, 32'h0000_0100, 2'b00, 2'b00, 1'b0}, // R11
        '{1'b1, 5'd19, 32'h0000_1000, 5'd19, 32'h0000_1000, 2'b00, 2'b00, 1'b0}, // R12
        '{1'b1, 5'd3,  32'h00AB_C000, 5'd3,  32'h00AB_C000, 2'b00, 2'b11, 1'b0}, // R5
        '{1'b1, 5'd4,  32'h0000_0020, 5'd4,  32'h0000_0020, 2'b11, 2'b00, 1'b0}, // R6
        '{1'b1, 5'd4,  32'h0000_0220, 5'd4,  32'h0000_0220, 2'b00, 2'b00, 1'b0}, // R6
        '{1'b1, 5'd0,  32'h8000_0001, 5'd16, 32'h0000_0500, 2'b11, 2'b00, 1'b0}, // R3 R4
        '{1'b1, 5'd0,  32'h8000_0001, 5'd0,  32'h8000_0011, 2'b00, 2'b00, 1'b0}, // R4
        '{1'b1, 5'd1,  32'h0000_FFFF, 5'd0,  32'h8000_0011, 2'b00, 2'b00, 1'b1}, // R10
        '{1'b1, 5'd28, 32'hFFFF_FFFF, 5'd3,  32'h00AB_C000, 2'b00, 2'b00, 1'b1}, // R10
        '{1'b1, 5'd2,  32'h0000_DEAD, 5'd2,  32'h0000_DEAD, 2'b00, 2'b00, 1'b0}, // R12
        '{1'b1, 5'd8,  32'h0000_0007, 5'd8,  32'h0000_0007, 2'b00, 2'b00, 1'b0}, // R12
        '{1'b1, 5'd18, 32'h0000_0400, 5'd18, 32'h0000_0400, 2'b00, 2'b00, 1'b0}, // R12
        '{1'b0, 5'd0,  32'h0000_0000, 5'd6,  32'h0000_0000, 2'b00, 2'b00, 1'b1}, // R10
        '{1'b1, 5'd0,  32'h0000_0011, 5'd16, 32'h0000_0100, 2'b11, 2'b00, 1'b0}  // R3 R4
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive before the edge, release and settle just after it.
    task automatic step(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                        input logic [4:0] ri);
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_data = wd; rd_en = 1'b1; rd_idx = ri;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    function automatic logic [31:0] eb(input int s);
        return eff_base[s*32 +: 32];
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        rd_idx = 5'd0; #1;
        chk("R1 cr0", rd_data, 32'h10);
        rd_idx = 5'd16; #1;
        chk("R1 efer", rd_data, 32'h0);
        chk("R1 flush/err", {27'd0, tlb_flush_all, tlb_flush_ng, err}, 32'h0);
        chk("R1 eff_es", eb(0), 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].we, VEC[i].wi, VEC[i].wd, VEC[i].ri);
            chk($sformatf("R12 vec%0d rd", i), rd_data, VEC[i].erd);
            chk($sformatf("R4 R6 vec%0d flush_all", i), {30'd0, tlb_flush_all}, {30'd0, VEC[i].efa});
            chk($sformatf("R5 vec%0d flush_ng", i), {30'd0, tlb_flush_ng}, {30'd0, VEC[i].eng});
            chk($sformatf("R10 vec%0d err", i), {31'd0, err}, {31'd0, VEC[i].eerr});
        end

        // R7: pulse drops one cycle after the CR3 write
        step(1'b1, 5'd3, 32'h1000, 5'd3);
        chk("R7 ng high", {30'd0, tlb_flush_ng}, 32'h3);
        @(posedge clk); #1;
        chk("R7 ng low", {30'd0, tlb_flush_ng}, 32'h0);
        chk("R10 err low", {31'd0, err}, 32'h0);

        // Effective base behaviour from a fresh reset
        do_reset();
        step(1'b1, 5'd19, 32'h1000, 5'd19);
        chk("R9 es eff legacy", eb(0), 32'h1000);
        step(1'b1, 5'd23, 32'h2000, 5'd23);
        chk("R9 fs eff", eb(4), 32'h2000);
        step(1'b1, 5'd16, 32'h100, 5'd16);
        step(1'b1, 5'd0, 32'h8000_0001, 5'd16);
        chk("R3 lma set", rd_data, 32'h500);
        step(1'b1, 5'd17, 32'h200, 5'd17);
        chk("R8 enter es", eb(0), 32'h0);
        step(1'b1, 5'd22, 32'h3000, 5'd22);
        chk("R9 ds stored", rd_data, 32'h3000);
        chk("R9 ds eff kept", eb(3), 32'h0);
        step(1'b1, 5'd24, 32'h4000, 5'd24);
        chk("R9 gs eff", eb(5), 32'h4000);
        step(1'b1, 5'd17, 32'h0, 5'd17);
        chk("R8 leave es", eb(0), 32'h1000);
        chk("R8 leave ds", eb(3), 32'h3000);
        chk("R8 fs untouched", eb(4), 32'h2000);
        // R10: illegal write leaves effective bases alone
        step(1'b1, 5'd7, 32'hFFFF_FFFF, 5'd0);
        chk("R10 err", {31'd0, err}, 32'h1);
        chk("R10 eff", eb(3), 32'h3000);
        chk("R2 cr0 kept", rd_data, 32'h8000_0011);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule